// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between a processor bus and two downstream PCI ports. It holds a small set of programmable address windows and checks a CPU address against them. Each port has one I/O window and four memory windows. One more window covers the chip's own register space. When an address falls inside an enabled window, the block reports which window matched, which port and which space it targets, and the address to issue on that target. The target address is the window's remap value plus the offset of the CPU address from the window start.

Software sets up the windows through a simple 32-bit register port. A write strobe commits data on the clock edge, and read data follows the register address combinationally. Each window is switched on by clearing its own bit in one shared enable register, so a cleared bit means the window is active. A bit in the configuration register chooses whether writing a window base also reloads the lower half of that window's remap value. The decode path is purely combinational from the CPU address.

Top module: `addrwin_top`

## Requirements
- R1: After reset, the configuration register (offset 0x00) reads 0x028000FF, the enable register (offset 0x01) reads 0x000FBFFF, and the internal-space base (offset 0x02) reads 0x0100F100.
- R2: The enable register is 21 bits wide. A write keeps data bits 20:0, and bits 31:21 always read as 0.
- R3: A window decodes only while its enable bit is 0. Window w (0 to 9) uses enable bit 9+w, and the register-space window (index 10) uses bit 20. Windows 0 to 4 belong to port 0 as I/O, mem0 to mem3. Windows 5 to 9 belong to port 1 in the same order.
- R4: A window spans from base[19:0]×65536 up to, but not including, that start plus (size[15:0]+1)×65536. The register-space window is always 65536 bytes long.
- R5: A base write keeps data under mask 0x030FFFFF for I/O windows and under mask 0x070FFFFF for memory windows. A size write keeps data bits 15:0, and an internal-base write keeps data bits 19:0.
- R6: While configuration bit 27 is 0, a base write also sets remap[31:16] to data[15:0] and remap[15:0] to 0, and leaves remap[63:32] unchanged. While bit 27 is 1, the remap is untouched.
- R7: A remap-low write (window offset +2) sets remap[31:16] to data[15:0] and clears remap[15:0], keeping remap[63:32]. A remap-high write (offset +3, memory windows only) sets remap[63:32] to data. Reads at +2 and +3 return remap[31:16] and remap[63:32].
- R8: On a hit, tgtAddr equals the window's remap plus (cpuAddr − window start), as a 64-bit value. The register-space window has a remap of 0.
- R9: When several enabled windows contain the address, the one with the lowest index is reported.
- R10: A configuration write stores data masked with 0x0E4E3BFF, and bit 23 always reads 1.
- R11: Port window w occupies offsets 0x10+4w (base), +1 (size), +2 (remap low) and +3 (remap high). Any other offset, including remap-high of the two I/O windows, reads 0 and ignores writes.
- R12: tgtSpace encodes I/O as 0, memory as 1 and register space as 2, and tgtPort gives the port number (0 for register space). On a miss, hit, winIdx, tgtPort, tgtSpace and tgtAddr are all 0.
- R13: After reset, the mem1 windows of both ports (indices 2 and 7) have remap 0. Every other memory window has remap equal to its reset base shifted left by 16, and each I/O window has remap base[15:0] shifted left by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register word offset |
| regWrEn | input | 1 | Register write strobe, committed at the clock edge |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| cpuAddr | input | 32 | CPU address to decode |
| hit | output | 1 | Address lies in an enabled window |
| winIdx | output | 4 | Index of the matching window |
| tgtPort | output | 1 | Target port number |
| tgtSpace | output | 2 | Target space: 0 I/O, 1 memory, 2 registers |
| tgtAddr | output | 64 | Translated target address |

## Verification
A corrupted base, size or enable bit shows up at the ports in the same cycle that cpuAddr is probed. The symptom is a missed or wrongly claimed edge address, such as the first byte past a window's end, or the wrong winIdx where windows overlap. A bad remap update, whether it is a missing reload, a reload made while bit 27 is set, or a clobbered upper half, appears in tgtAddr on the next decode. It also appears in the remap-low and remap-high readback one cycle after the write. Mis-decoded offsets show up as nonzero reads from unmapped addresses, or as a write to an unmapped address that changes the enable or configuration register.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
  localparam int NUM_PORTS    = 2;
  localparam int MEM_PER_PORT = 4;
  localparam int WIN_PER_PORT = MEM_PER_PORT + 1;
  localparam int NUM_PWIN     = NUM_PORTS * WIN_PER_PORT;
  localparam int NUM_WIN      = NUM_PWIN + 1;
  localparam int IDX_W        = $clog2(NUM_WIN);
  localparam int PORT_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int REG_AW       = 8;
  localparam int DATA_W       = 32;
  localparam int CPU_W        = 32;
  localparam int GRAN         = 16;
  localparam int BASE_FLD     = 20;
  localparam int SPAN_W       = BASE_FLD + GRAN;
  localparam int SIZE_W       = 16;
  localparam int REMAP_W      = 64;
  localparam int EN_W         = 21;
  localparam int EN_FIRST     = 9;
  localparam int EN_REGS      = 20;
  localparam int CFG_RELOAD   = 27;
  localparam int CFG_ONE      = 23;

  localparam logic [DATA_W-1:0] CFG_MASK   = 32'h0E4E_3BFF;
  localparam logic [DATA_W-1:0] IO_MASK    = 32'h030F_FFFF;
  localparam logic [DATA_W-1:0] MEM_MASK   = 32'h070F_FFFF;
  localparam logic [DATA_W-1:0] IBASE_MASK = 32'h000F_FFFF;
  localparam logic [DATA_W-1:0] CFG_RST    = 32'h0280_00FF;
  localparam logic [EN_W-1:0]   EN_RST     = 21'h0F_BFFF;
  localparam logic [DATA_W-1:0] IBASE_RST  = 32'h0100_F100;

  localparam logic [REG_AW-1:0] OFS_CFG   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_EN    = 8'h01;
  localparam logic [REG_AW-1:0] OFS_IBASE = 8'h02;
  localparam int                OFS_WIN0  = 'h10;
  localparam int                OFS_WEND  = OFS_WIN0 + 4 * NUM_PWIN;

  typedef enum logic [1:0] {SPC_IO = 2'd0, SPC_MEM = 2'd1, SPC_REGS = 2'd2} space_e;
  typedef enum logic [2:0] {RD_NONE, RD_CFG, RD_EN, RD_IBASE,
                            RD_BASE, RD_SIZE, RD_RLO, RD_RHI} rdKind_e;

  typedef struct packed {
    logic                cfgWr;
    logic                enWr;
    logic                ibaseWr;
    logic [NUM_PWIN-1:0] baseWr;
    logic [NUM_PWIN-1:0] sizeWr;
    logic [NUM_PWIN-1:0] rloWr;
    logic [NUM_PWIN-1:0] rhiWr;
    rdKind_e             rdKind;
    logic [IDX_W-1:0]    rdWin;
  } ctlStrobe_t;

  function automatic logic isIoWin(input int w);
    return (w % WIN_PER_PORT) == 0;
  endfunction

  function automatic int portOf(input int w);
    return w / WIN_PER_PORT;
  endfunction

  function automatic int enBitOf(input int w);
    return (w < NUM_PWIN) ? EN_FIRST + w : EN_REGS;
  endfunction

  function automatic logic [DATA_W-1:0] rstBase(input int w);
    case (w)
      0: return 32'h0100_F800;  1: return 32'h0100_C000;
      2: return 32'h0100_F900;  3: return 32'h0100_F400;
      4: return 32'h0100_F600;  5: return 32'h0100_FE00;
      6: return 32'h0100_8000;  7: return 32'h0100_FD00;
      8: return 32'h0100_2600;  default: return 32'h0100_FF80;
    endcase
  endfunction

  function automatic logic [SIZE_W-1:0] rstSize(input int w);
    case (w)
      1: return 16'h1FFF;  3, 4, 8: return 16'h01FF;
      6: return 16'h3FFF;  9: return 16'h007F;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic [REMAP_W-1:0] rstRemap(input int w);
    logic [DATA_W-1:0] b;
    b = rstBase(w);
    if ((w % WIN_PER_PORT) == 2) return '0;
    if (isIoWin(w)) return {32'b0, b[15:0], 16'b0};
    return REMAP_W'(b) << GRAN;
  endfunction
endpackage

// File: rtl/addrwin_ctrl.sv
module addrwin_ctrl
  import addrwin_pkg::*;
(
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobe_t        strb
);
  always_comb begin
    int w;
    int fld;
    strb = '0;
    strb.rdKind = RD_NONE;
    w = (int'(regAddr) - OFS_WIN0) / 4;
    fld = int'(regAddr[1:0]);
    if (regAddr == OFS_CFG) begin
      strb.rdKind = RD_CFG;
      strb.cfgWr  = regWrEn;
    end else if (regAddr == OFS_EN) begin
      strb.rdKind = RD_EN;
      strb.enWr   = regWrEn;
    end else if (regAddr == OFS_IBASE) begin
      strb.rdKind  = RD_IBASE;
      strb.ibaseWr = regWrEn;
    end else if (int'(regAddr) >= OFS_WIN0 && int'(regAddr) < OFS_WEND &&
                 !(fld == 3 && isIoWin(w))) begin
      strb.rdWin = IDX_W'(w);
      case (fld)
        0: begin strb.rdKind = RD_BASE; strb.baseWr[w] = regWrEn; end
        1: begin strb.rdKind = RD_SIZE; strb.sizeWr[w] = regWrEn; end
        2: begin strb.rdKind = RD_RLO;  strb.rloWr[w]  = regWrEn; end
        default: begin strb.rdKind = RD_RHI; strb.rhiWr[w] = regWrEn; end
      endcase
    end
  end
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
  import addrwin_pkg::*;
(
  input  logic [CPU_W-1:0]  cpuAddr,
  input  logic [SPAN_W-1:0] startAddr,
  input  logic [SIZE_W:0]   lenUnits,
  input  logic              enable,
  output logic              inWin,
  output logic [SPAN_W-1:0] offset
);
  localparam int LIM_W = SIZE_W + 1 + GRAN;
  logic [SPAN_W:0]  diff;
  logic [LIM_W-1:0] limit;

  assign diff   = {1'b0, SPAN_W'(cpuAddr)} - {1'b0, startAddr};
  assign limit  = {lenUnits, {GRAN{1'b0}}};
  assign inWin  = enable && !diff[SPAN_W] && (diff[SPAN_W-1:0] < SPAN_W'(limit));
  assign offset = diff[SPAN_W-1:0];
endmodule

// File: rtl/addrwin_dp.sv
module addrwin_dp
  import addrwin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [CPU_W-1:0]   cpuAddr,
  output logic               hit,
  output logic [IDX_W-1:0]   winIdx,
  output logic [PORT_W-1:0]  tgtPort,
  output logic [1:0]         tgtSpace,
  output logic [REMAP_W-1:0] tgtAddr
);
  logic [DATA_W-1:0]  cfgReg, ibaseReg;
  logic [EN_W-1:0]    enReg;
  logic [DATA_W-1:0]  baseReg  [NUM_PWIN];
  logic [SIZE_W-1:0]  sizeReg  [NUM_PWIN];
  logic [REMAP_W-1:0] remapReg [NUM_PWIN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= CFG_RST;
      enReg    <= EN_RST;
      ibaseReg <= IBASE_RST;
      for (int w = 0; w < NUM_PWIN; w++) begin
        baseReg[w]  <= rstBase(w);
        sizeReg[w]  <= rstSize(w);
        remapReg[w] <= rstRemap(w);
      end
    end else begin
      if (strb.cfgWr)   cfgReg   <= (regWrData & CFG_MASK) | (DATA_W'(1) << CFG_ONE);
      if (strb.enWr)    enReg    <= regWrData[EN_W-1:0];
      if (strb.ibaseWr) ibaseReg <= regWrData & IBASE_MASK;
      for (int w = 0; w < NUM_PWIN; w++) begin
        if (strb.baseWr[w]) begin
          baseReg[w] <= regWrData & (isIoWin(w) ? IO_MASK : MEM_MASK);
          if (!cfgReg[CFG_RELOAD]) remapReg[w][31:0] <= {regWrData[15:0], 16'b0};
        end
        if (strb.sizeWr[w]) sizeReg[w] <= regWrData[SIZE_W-1:0];
        if (strb.rloWr[w])  remapReg[w][31:0] <= {regWrData[15:0], 16'b0};
        if (strb.rhiWr[w])  remapReg[w][63:32] <= regWrData;
      end
    end
  end

  always_comb begin
    case (strb.rdKind)
      RD_CFG:   regRdData = cfgReg;
      RD_EN:    regRdData = DATA_W'(enReg);
      RD_IBASE: regRdData = ibaseReg;
      RD_BASE:  regRdData = baseReg[strb.rdWin];
      RD_SIZE:  regRdData = DATA_W'(sizeReg[strb.rdWin]);
      RD_RLO:   regRdData = DATA_W'(remapReg[strb.rdWin][31:16]);
      RD_RHI:   regRdData = remapReg[strb.rdWin][63:32];
      default:  regRdData = '0;
    endcase
  end

  logic [NUM_WIN-1:0] hitVec;
  logic [SPAN_W-1:0]  offVec [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [SPAN_W-1:0] winStart;
    logic [SIZE_W:0]   winLen;
    if (i < NUM_PWIN) begin : g_port
      assign winStart = {baseReg[i][BASE_FLD-1:0], {GRAN{1'b0}}};
      assign winLen   = {1'b0, sizeReg[i]} + 1'b1;
    end else begin : g_regs
      assign winStart = {ibaseReg[BASE_FLD-1:0], {GRAN{1'b0}}};
      assign winLen   = (SIZE_W+1)'(1);
    end
    addrwin_match u_match (
      .cpuAddr   (cpuAddr),
      .startAddr (winStart),
      .lenUnits  (winLen),
      .enable    (!enReg[enBitOf(i)]),
      .inWin     (hitVec[i]),
      .offset    (offVec[i])
    );
  end

  always_comb begin
    int pick;
    pick     = 0;
    hit      = 1'b0;
    winIdx   = '0;
    tgtPort  = '0;
    tgtSpace = SPC_IO;
    tgtAddr  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) pick = i;
    end
    if (|hitVec) begin
      hit    = 1'b1;
      winIdx = IDX_W'(pick);
      if (pick < NUM_PWIN) begin
        tgtPort  = PORT_W'(portOf(pick));
        tgtSpace = isIoWin(pick) ? SPC_IO : SPC_MEM;
        tgtAddr  = remapReg[pick] + REMAP_W'(offVec[pick]);
      end else begin
        tgtSpace = SPC_REGS;
        tgtAddr  = REMAP_W'(offVec[pick]);
      end
    end
  end
endmodule

// File: rtl/addrwin_top.sv
module addrwin_top
  import addrwin_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   regAddr,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  input  logic [31:0]  cpuAddr,
  output logic         hit,
  output logic [3:0]   winIdx,
  output logic [0:0]   tgtPort,
  output logic [1:0]   tgtSpace,
  output logic [63:0]  tgtAddr
);
  ctlStrobe_t strb;

  addrwin_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  addrwin_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cpuAddr   (cpuAddr),
    .hit       (hit),
    .winIdx    (winIdx),
    .tgtPort   (tgtPort),
    .tgtSpace  (tgtSpace),
    .tgtAddr   (tgtAddr)
  );
endmodule

// File: rtl/addrwin_chk.sv
module addrwin_chk
  import addrwin_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  regAddr,
  input logic [31:0] regRdData,
  input logic        hit,
  input logic [3:0]  winIdx,
  input logic [0:0]  tgtPort,
  input logic [1:0]  tgtSpace,
  input logic [63:0] tgtAddr
);
  // R12: a miss drives every decode output to zero
  a_r12_nohit_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (winIdx == 0 && tgtPort == 0 && tgtSpace == 0 && tgtAddr == 0));

  // R3: reported index is a real window
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (int'(winIdx) < NUM_WIN));

  // R3 / R12: port follows the window's position in the index order
  a_r12_port_of_win: assert property (@(posedge clk) disable iff (!rstN)
    (hit && int'(winIdx) < NUM_PWIN) |-> (int'(tgtPort) == int'(winIdx) / WIN_PER_PORT));

  // R12: register-space window targets space 2 on port 0
  a_r12_regs_space: assert property (@(posedge clk) disable iff (!rstN)
    (hit && int'(winIdx) == NUM_PWIN) |-> (tgtSpace == 2'd2 && tgtPort == 0));

  // R12: I/O windows report space 0, memory windows space 1
  a_r12_io_mem_space: assert property (@(posedge clk) disable iff (!rstN)
    (hit && int'(winIdx) < NUM_PWIN) |->
      (tgtSpace == (((int'(winIdx) % WIN_PER_PORT) == 0) ? 2'd0 : 2'd1)));

  // R2: upper bits of the enable register never read back
  a_r2_en_width: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h01) |-> (regRdData[31:21] == 0));

  // R10: configuration bit 23 is stuck at one
  a_r10_cfg_one: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h00) |-> regRdData[23]);

  // R11: offsets between the fixed registers and the windows read zero
  a_r11_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > 8'h02 && regAddr < 8'h10) |-> (regRdData == 0));
endmodule

bind addrwin_top addrwin_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .hit       (hit),
  .winIdx    (winIdx),
  .tgtPort   (tgtPort),
  .tgtSpace  (tgtSpace),
  .tgtAddr   (tgtAddr)
);

// File: tb/sim_addrwin_top.sv
module sim_addrwin_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [31:0] cpuAddr;
  logic        hit;
  logic [3:0]  winIdx;
  logic [0:0]  tgtPort;
  logic [1:0]  tgtSpace;
  logic [63:0] tgtAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    bit          isDec;
    logic [63:0] expVal;
    bit          expHit;
    int          expIdx;
    int          expPort;
    int          expSpace;
    string       tag;
  } item_t;

  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addrwin_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cpuAddr(cpuAddr),
    .hit(hit), .winIdx(winIdx), .tgtPort(tgtPort), .tgtSpace(tgtSpace),
    .tgtAddr(tgtAddr)
  );

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = a;
    it.isDec = 0; it.expVal = 64'(e); it.expHit = 0;
    it.expIdx = 0; it.expPort = 0; it.expSpace = 0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expectDec(input logic [31:0] a, input bit h, input int idx,
                           input int port, input int spc, input logic [63:0] t,
                           input string tag);
    item_t it;
    @(posedge clk); #1;
    regWrEn = 1'b0; cpuAddr = a;
    it.isDec = 1; it.expHit = h; it.expIdx = h ? idx : 0;
    it.expPort = h ? port : 0; it.expSpace = h ? spc : 0;
    it.expVal = h ? t : 64'h0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: checks each queued expectation in the middle of its cycle
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (!it.isDec) begin
        if (regRdData !== it.expVal[31:0]) begin
          nFails++;
          $display("FAIL %s read @%h: actual %h expected %h", it.tag, regAddr,
                   regRdData, it.expVal[31:0]);
        end
      end else if (hit !== it.expHit || int'(winIdx) != it.expIdx ||
                   int'(tgtPort) != it.expPort || int'(tgtSpace) != it.expSpace ||
                   tgtAddr !== it.expVal) begin
        nFails++;
        $display("FAIL %s decode %h: actual hit=%0d idx=%0d port=%0d spc=%0d tgt=%h expected hit=%0d idx=%0d port=%0d spc=%0d tgt=%h",
                 it.tag, cpuAddr, hit, winIdx, tgtPort, tgtSpace, tgtAddr,
                 it.expHit, it.expIdx, it.expPort, it.expSpace, it.expVal);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = 8'h00; regWrEn = 1'b0; regWrData = '0; cpuAddr = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    expectRead(8'h00, 32'h0280_00FF, "R1");
    expectRead(8'h01, 32'h000F_BFFF, "R1");
    expectRead(8'h02, 32'h0100_F100, "R1");
    expectRead(8'h1A, 32'h0, "R13");
    expectRead(8'h1B, 32'h0, "R13");
    expectRead(8'h16, 32'h0000_C000, "R13");
    expectRead(8'h17, 32'h0000_0100, "R13");
    expectDec(32'hFE00_1234, 1, 5, 1, 0, 64'hFE00_1234, "R8");
    expectDec(32'hFEFF_FFFF, 1, 5, 1, 0, 64'hFEFF_FFFF, "R4");
    expectDec(32'hF100_0010, 1, 10, 0, 2, 64'h10, "R12");
    expectDec(32'hC000_0000, 0, 0, 0, 0, 64'h0, "R3");

    // enable register width and bit mapping
    regWrite(8'h01, 32'hFFFF_FBFF);
    expectRead(8'h01, 32'h001F_FBFF, "R2");
    expectDec(32'hC000_0100, 1, 1, 0, 1, 64'h100_C000_0100, "R8");
    expectDec(32'hDFFF_FFFF, 1, 1, 0, 1, 64'h100_DFFF_FFFF, "R4");
    expectDec(32'hE000_0000, 0, 0, 0, 0, 64'h0, "R4");
    expectDec(32'hFE00_1234, 0, 0, 0, 0, 64'h0, "R3");

    // base/size masks and remap reload
    regWrite(8'h10, 32'hFFFF_FFFF);
    expectRead(8'h10, 32'h030F_FFFF, "R5");
    expectRead(8'h12, 32'h0000_FFFF, "R6");
    regWrite(8'h14, 32'hFFFF_FFFF);
    expectRead(8'h14, 32'h070F_FFFF, "R5");
    expectRead(8'h16, 32'h0000_FFFF, "R6");
    expectRead(8'h17, 32'h0000_0100, "R6");
    regWrite(8'h15, 32'hFFFF_0003);
    expectRead(8'h15, 32'h0000_0003, "R5");

    // configuration mask
    regWrite(8'h00, 32'hFFFF_FFFF);
    expectRead(8'h00, 32'h0ECE_3BFF, "R10");
    regWrite(8'h00, 32'h0);
    expectRead(8'h00, 32'h0080_0000, "R10");
    regWrite(8'h00, 32'h0800_0000);
    expectRead(8'h00, 32'h0880_0000, "R10");
    regWrite(8'h14, 32'h0100_2000);
    expectRead(8'h14, 32'h0100_2000, "R5");
    expectRead(8'h16, 32'h0000_FFFF, "R6");

    // remap low/high semantics and translation
    regWrite(8'h16, 32'hABCD_1234);
    expectRead(8'h16, 32'h0000_1234, "R7");
    regWrite(8'h17, 32'h0000_0007);
    expectRead(8'h17, 32'h0000_0007, "R7");
    expectRead(8'h16, 32'h0000_1234, "R7");
    expectDec(32'h2001_2345, 1, 1, 0, 1, 64'h7_1235_2345, "R8");
    expectDec(32'h2003_FFFF, 1, 1, 0, 1, 64'h7_1237_FFFF, "R4");
    expectDec(32'h2004_0000, 0, 0, 0, 0, 64'h0, "R4");

    // overlapping windows: lowest index wins
    regWrite(8'h1C, 32'h0000_2000);
    regWrite(8'h1D, 32'h0);
    regWrite(8'h01, 32'h001F_EBFF);
    expectDec(32'h2000_0010, 1, 1, 0, 1, 64'h7_1234_0010, "R9");
    regWrite(8'h01, 32'h001F_EFFF);
    expectDec(32'h2000_0010, 1, 3, 0, 1, 64'h100_F400_0010, "R9");

    // port 1 memory window with reload enabled again
    regWrite(8'h00, 32'h0);
    regWrite(8'h2C, 32'h0000_3000);
    regWrite(8'h2D, 32'h0);
    regWrite(8'h01, 32'h001E_FFFF);
    expectDec(32'h3000_0ABC, 1, 7, 1, 1, 64'h3000_0ABC, "R12");
    expectDec(32'h2000_0010, 0, 0, 0, 0, 64'h0, "R12");

    // unmapped offsets
    expectRead(8'hFF, 32'h0, "R11");
    expectRead(8'h03, 32'h0, "R11");
    regWrite(8'hFF, 32'hFFFF_FFFF);
    expectRead(8'h01, 32'h001E_FFFF, "R11");
    expectRead(8'h00, 32'h0080_0000, "R11");
    regWrite(8'h13, 32'h0000_0055);
    expectRead(8'h13, 32'h0, "R11");
    expectRead(8'h12, 32'h0000_FFFF, "R11");

    // internal-space base and register window
    regWrite(8'h02, 32'hFFFF_1234);
    expectRead(8'h02, 32'h000F_1234, "R5");
    regWrite(8'h02, 32'h0000_4000);
    regWrite(8'h01, 32'h000E_FFFF);
    expectDec(32'h4000_FFFC, 1, 10, 0, 2, 64'hFFFC, "R4");
    expectDec(32'h4001_0000, 0, 0, 0, 0, 64'h0, "R4");
    expectDec(32'h3000_0000, 1, 7, 1, 1, 64'h3000_0000, "R8");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule